// File: doc/BRIEF.md
# Asynchronous memory cycle master

This block drives memory cycles onto an asynchronous external bus. The bus has a 19-bit address, an 8-bit data path and three active-low strobes: a memory request, a read strobe and a write strobe. The data path is split into separate output, output-enable and input vectors, so a pad ring or a tri-state wrapper can join them. Bus ownership is assumed to be held already. No arbitration and no processor handshaking is done here.

A command is given by a one-cycle `start` with an operation code, a start address, a length and a data byte. The block runs five operations: single read, single write, fill a range with a constant, block write and block read. Block-write bytes come in through a valid/ready byte stream. Every byte that is read leaves through a second valid/ready stream. Every strobe has a fixed width in clocks. For bursts the memory request stays low from the first byte to the last while the address counts up. `done` pulses for one cycle when the command has finished.

Top module: `memcyc_master`

## Requirements
- R1: After reset, `mreq_n`, `rd_n` and `wr_n` are high, and `bus_doe`, `busy`, `done`, `rd_valid` and `wr_ready` are low.
- R2: Single write (`op`=1) first lowers `mreq_n` and drives `wdata` with `bus_doe` high. It then holds `wr_n` low for exactly 2 clocks and raises `wr_n` one clock before `mreq_n`. The byte lands at `addr`.
- R3: Single read (`op`=0) holds `rd_n` low for exactly 3 clocks with `bus_doe` low. It samples `bus_din` in the last low clock and delivers that byte on the read stream. `rd_n` and `mreq_n` rise together.
- R4: Fill (`op`=2) writes `wdata` to `len` consecutive addresses starting at `addr`. `mreq_n` falls only once for the whole range.
- R5: Block write (`op`=3) takes one stream byte per address, in stream order, starting at `addr`. Each byte is on `bus_dout` with `bus_doe` high for at least 2 clocks before `wr_n` falls.
- R6: Block read (`op`=4) delivers the bytes at `len` consecutive addresses in address order on the read stream, under one `mreq_n` low period. A held-back `rd_ready` loses no byte, and `rd_valid`/`rd_byte` stay stable until they are accepted.
- R7: For operations 2, 3 and 4, a `len` of zero gives `done` in the cycle after `start` is taken, and `mreq_n` never goes low.
- R8: `start` is ignored while `busy` is high, and it is also ignored for operation codes 5 to 7.
- R9: `rd_n` and `wr_n` are never low together, and neither one is low while `mreq_n` is high.
- R10: `bus_doe` is low whenever `rd_n` is low and whenever the block is idle.
- R11: `done` lasts one cycle, and `mreq_n` is high while `done` is high.
- R12: Burst addresses wrap modulo 2^19, so the address after 0x7FFFF is 0x00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when idle |
| op | input | 3 | Operation: 0 read, 1 write, 2 fill, 3 block write, 4 block read |
| addr | input | 19 | Start address |
| len | input | 20 | Byte count for operations 2 to 4 |
| wdata | input | 8 | Byte for single write and fill |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | input | 1 | Block-write byte valid |
| wr_ready | output | 1 | Block-write byte accepted |
| wr_byte | input | 8 | Block-write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer accepts read byte |
| rd_byte | output | 8 | Read byte |
| bus_addr | output | 19 | Bus address |
| bus_dout | output | 8 | Bus data out |
| bus_doe | output | 1 | Bus data output enable |
| bus_din | input | 8 | Bus data in |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions check on every cycle that each strobe is exclusive and sits inside the memory request. They also check the exact width of each strobe, that the write strobe rises before the request, that the output enable is off during reads, that `done` is a single-cycle pulse, and that a pending read byte is held stable. Only the bench scenarios can show that the right bytes reach the right addresses. This covers fill ranges, stream ordering across a random `rd_ready` and `wr_valid`, address wrap-around, the single request period per burst, zero-length completion, and commands dropped while busy or with an unused code.

// File: rtl/memcyc_master.sv
module memcyc_master #(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 20,
  parameter int SETUP_CYC = 2,
  parameter int WR_LOW    = 2,
  parameter int RD_LOW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_byte,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              wr_n
);

  localparam int MAX_A = (SETUP_CYC > WR_LOW) ? SETUP_CYC : WR_LOW;
  localparam int MAX_C = (MAX_A > RD_LOW) ? MAX_A : RD_LOW;
  localparam int CNT_W = $clog2(MAX_C) + 1;

  localparam logic [2:0] OP_RD   = 3'd0;
  localparam logic [2:0] OP_WR   = 3'd1;
  localparam logic [2:0] OP_BWR  = 3'd3;
  localparam logic [2:0] OP_BRD  = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SETUP, S_STROBE, S_GAP, S_FIN} state_t;

  state_t            st;
  logic              rd_op, bwr_op;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic [LEN_W-1:0]  rem;
  logic [CNT_W-1:0]  cnt;

  wire op_ok  = op <= OP_BRD;
  wire single = (op == OP_RD) || (op == OP_WR);
  wire stall  = rd_op && rd_valid && !rd_ready;
  wire [CNT_W-1:0] strobe_last = rd_op ? CNT_W'(RD_LOW - 1) : CNT_W'(WR_LOW - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rd_op    <= 1'b0;
      bwr_op   <= 1'b0;
      a_q      <= '0;
      d_q      <= '0;
      rem      <= '0;
      cnt      <= '0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (start && op_ok) begin
          rd_op  <= (op == OP_RD) || (op == OP_BRD);
          bwr_op <= (op == OP_BWR);
          a_q    <= addr;
          d_q    <= wdata;
          rem    <= single ? LEN_W'(1) : len;
          cnt    <= '0;
          if (!single && len == '0) st <= S_FIN;
          else if (op == OP_BWR)    st <= S_FETCH;
          else                      st <= S_SETUP;
        end
        S_FETCH: if (wr_valid) begin
          d_q <= wr_byte;
          st  <= S_SETUP;
        end
        S_SETUP: if (!stall) begin
          if (cnt == CNT_W'(SETUP_CYC - 1)) begin
            cnt <= '0;
            st  <= S_STROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STROBE: if (cnt == strobe_last) begin
          cnt <= '0;
          rem <= rem - 1'b1;
          if (rd_op) begin
            rd_byte  <= bus_din;
            rd_valid <= 1'b1;
          end
          st <= (rd_op && rem == LEN_W'(1)) ? S_FIN : S_GAP;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_GAP: if (rem == '0) begin
          st <= S_FIN;
        end else begin
          a_q <= a_q + 1'b1;
          st  <= bwr_op ? S_FETCH : S_SETUP;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mreq_n   = !(st == S_FETCH || st == S_SETUP || st == S_STROBE || st == S_GAP);
  assign rd_n     = !(st == S_STROBE && rd_op);
  assign wr_n     = !(st == S_STROBE && !rd_op);
  assign bus_doe  = !rd_op && (st == S_SETUP || st == S_STROBE || st == S_GAP);
  assign bus_dout = d_q;
  assign bus_addr = a_q;
  assign busy     = st != S_IDLE;
  assign done     = st == S_FIN;
  assign wr_ready = st == S_FETCH;

endmodule

// File: rtl/memcyc_master_chk.sv
module memcyc_master_chk #(
  parameter int DATA_W = 8,
  parameter int WR_LOW = 2,
  parameter int RD_LOW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mreq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              bus_doe,
  input logic              busy,
  input logic              done,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_byte
);

  logic [7:0] wl, rl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wl <= '0;
      rl <= '0;
    end else begin
      wl <= wr_n ? 8'd0 : wl + 8'd1;
      rl <= rd_n ? 8'd0 : rl + 8'd1;
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  // R9
  strobe_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> !mreq_n);
  // R10
  doe_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !bus_doe);
  // R10
  doe_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !bus_doe);
  // R2
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_n) |-> wl == 8'(WR_LOW));
  // R2
  wr_before_req_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_n) |-> !mreq_n);
  // R3
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_n) |-> rl == 8'(RD_LOW));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R11
  done_req_high_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> mreq_n);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_byte)));

endmodule

bind memcyc_master memcyc_master_chk #(.DATA_W(DATA_W), .WR_LOW(WR_LOW), .RD_LOW(RD_LOW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
  .bus_doe(bus_doe), .busy(busy), .done(done), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_byte(rd_byte)
);

// File: tb/memcyc_master_tb_top.sv
module memcyc_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [18:0] addr = '0;
  logic [19:0] len = '0;
  logic [7:0]  wdata = '0;
  logic        busy, done;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_byte = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_byte;
  logic [18:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_doe;
  logic [7:0]  bus_din = '0;
  logic        mreq_n, rd_n, wr_n;

  always #10 clk = ~clk;

  memcyc_master dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .len(len),
    .wdata(wdata), .busy(busy), .done(done), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_byte(wr_byte), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_byte(rd_byte), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] mem [logic [18:0]];
  logic [7:0] wbuf [0:63];
  logic [7:0] rq [$];
  int  wr_idx = 0, wr_cnt = 0;
  bit  wr_hs = 0;
  int  req_falls = 0;
  bit  prev_req = 1;
  int  wl = 0, rl = 0, sc = 0;
  logic [7:0] prev_dout = '0;
  bit  single_rd = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b10101};
  endfunction

  function automatic logic [7:0] memget(input logic [18:0] a);
    if (mem.exists(a)) return mem[a];
    return pat(a);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_req && !mreq_n) req_falls++;
      prev_req = mreq_n;
      if (!wr_n) begin
        if (wl == 0) check(sc >= 2, "R5 setup before WR low", sc, 2);
        check(bus_doe, "R2 doe during WR low", bus_doe, 1);
        mem[bus_addr] = bus_dout;
        wl++;
      end else if (wl > 0) begin
        check(wl == 2, "R2 WR low width", wl, 2);
        check(!mreq_n, "R2 WR rises before MREQ", mreq_n, 0);
        wl = 0;
      end
      if (!rd_n) rl++;
      else if (rl > 0) begin
        check(rl == 3, "R3 RD low width", rl, 3);
        if (single_rd) check(mreq_n, "R3 RD and MREQ rise together", mreq_n, 1);
        rl = 0;
      end
      if (!mreq_n && bus_doe && wr_n && bus_dout == prev_dout) sc++;
      else if (!mreq_n && bus_doe && wr_n) sc = 1;
      else sc = 0;
      prev_dout = bus_dout;
    end
    if (wr_hs) wr_idx++;
    wr_valid = (wr_idx < wr_cnt) && ($urandom_range(0, 3) != 0);
    wr_byte  = wbuf[wr_idx & 63];
    wr_hs    = wr_valid && wr_ready;
    rd_ready = $urandom_range(0, 2) != 0;
    if (rd_valid && rd_ready) rq.push_back(rd_byte);
    bus_din  = (!mreq_n && !rd_n) ? memget(bus_addr) : 8'h00;
  end

  task automatic kick(input logic [2:0] o, input logic [18:0] a, input logic [19:0] n, input logic [7:0] d);
    int t;
    rq.delete();
    req_falls = 0;
    wr_idx = 0;
    wr_hs = 0;
    wr_cnt = (o == 3'd3) ? int'(n) : 0;
    single_rd = (o == 3'd0);
    @(negedge clk);
    op = o; addr = a; len = n; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(done, "R11 done reached", done, 1);
    @(negedge clk);
    check(!done, "R11 done single cycle", done, 0);
    for (int k = 0; k < 60 && rd_valid; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic verify(input logic [2:0] o, input logic [18:0] a, input logic [19:0] n, input logic [7:0] d);
    case (o)
      3'd0: begin
        check(rq.size() == 1, "R3 one read byte", rq.size(), 1);
        if (rq.size() == 1) check(rq[0] == memget(a), "R3 read data", rq[0], memget(a));
      end
      3'd1: check(memget(a) == d, "R2 write data", memget(a), d);
      3'd2: begin
        for (int i = 0; i < int'(n); i++)
          check(memget(a + 19'(i)) == d, "R4 fill data", memget(a + 19'(i)), d);
        check(req_falls == (n != 0 ? 1 : 0), "R4 one MREQ per fill", req_falls, n != 0);
      end
      3'd3: begin
        for (int i = 0; i < int'(n); i++)
          check(memget(a + 19'(i)) == wbuf[i], "R5 block write data", memget(a + 19'(i)), wbuf[i]);
        check(wr_idx == int'(n), "R5 stream bytes taken", wr_idx, n);
      end
      default: begin
        check(rq.size() == int'(n), "R6 block read count", rq.size(), n);
        for (int i = 0; i < int'(n) && i < rq.size(); i++)
          check(rq[i] == memget(a + 19'(i)), "R6 block read data", rq[i], memget(a + 19'(i)));
        check(req_falls == (n != 0 ? 1 : 0), "R6 one MREQ per burst", req_falls, n != 0);
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mreq_n && rd_n && wr_n, "R1 strobes high in reset", {mreq_n, rd_n, wr_n}, 7);
    check(!bus_doe && !busy && !done && !rd_valid && !wr_ready, "R1 outputs low in reset",
          {bus_doe, busy, done, rd_valid, wr_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    kick(3'd1, 19'h00123, 20'd0, 8'h5A); verify(3'd1, 19'h00123, 20'd0, 8'h5A);
    kick(3'd0, 19'h00123, 20'd0, 8'h00); verify(3'd0, 19'h00123, 20'd0, 8'h00);

    // R7 zero length: done one cycle after start, no request
    for (int z = 2; z <= 4; z++) begin
      rq.delete(); req_falls = 0;
      @(negedge clk);
      op = 3'(z); addr = 19'h00200; len = 20'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done, "R7 zero length done next cycle", done, 1);
      @(negedge clk);
      check(req_falls == 0, "R7 zero length no MREQ", req_falls, 0);
      check(rq.size() == 0, "R7 zero length no data", rq.size(), 0);
    end

    // R12 wrap at top of address space
    kick(3'd2, 19'h7FFFE, 20'd4, 8'hC3);
    check(memget(19'h7FFFF) == 8'hC3, "R12 top address written", memget(19'h7FFFF), 8'hC3);
    check(memget(19'h00000) == 8'hC3, "R12 wrapped to zero", memget(19'h00000), 8'hC3);
    check(memget(19'h00001) == 8'hC3, "R12 wrapped to one", memget(19'h00001), 8'hC3);
    check(memget(19'h00002) == pat(19'h00002), "R12 stops after length", memget(19'h00002), pat(19'h00002));

    // R8 start while busy ignored
    rq.delete(); req_falls = 0; wr_cnt = 0; single_rd = 0;
    @(negedge clk);
    op = 3'd2; addr = 19'h01000; len = 20'd6; wdata = 8'h11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op = 3'd1; addr = 19'h02000; wdata = 8'hEE; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(memget(19'h02000) == pat(19'h02000), "R8 start while busy ignored", memget(19'h02000), pat(19'h02000));
    check(memget(19'h01005) == 8'h11, "R8 running fill unaffected", memget(19'h01005), 8'h11);

    // R8 unused op code ignored
    req_falls = 0;
    @(negedge clk);
    op = 3'd6; addr = 19'h03000; len = 20'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy, "R8 unused op stays idle", busy, 0);
    repeat (3) @(negedge clk);
    check(req_falls == 0 && !done, "R8 unused op no cycle", req_falls, 0);

    for (int it = 0; it < 40; it++) begin
      logic [2:0]  o;
      logic [18:0] a;
      logic [19:0] n;
      logic [7:0]  d;
      o = 3'($urandom_range(0, 4));
      a = (it % 5 == 0) ? 19'h7FFF0 + 19'($urandom_range(0, 15)) : 19'($urandom);
      n = 20'($urandom_range(1, 24));
      d = 8'($urandom);
      for (int i = 0; i < 64; i++) wbuf[i] = 8'($urandom);
      kick(o, a, n, d);
      verify(o, a, n, d);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    $urandom(32'd1234);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule